// File: doc/BRIEF.md
# Queued Serial Transmit Channel

This block is the transmit half of an asynchronous serial port. A host bus writes bytes into a small queue and writes command codes that switch the channel on, switch it off or clear it. A shifter takes bytes from the queue and sends each one on a single line as a start bit, eight data bits (least significant first) and a stop bit. Bit timing comes from an oversampling tick supplied from outside.

The channel reports two status levels. One shows that the queue can take another byte. The other shows that the queue and the shifter have both gone quiet. A service request tells the host to refill the queue. The host chooses whether that request waits until the queue is empty or fires once at least half of the queue is free. The queue holds 8 or 16 bytes, selected by a mode input.

Switching the channel off withdraws the service request and refuses new bytes at once. Bytes already queued and the character on the line are still sent, so the host can shut the channel down as soon as its own buffer runs dry and does not need to poll for completion.

Top module: `uart_tx_chan`

## Requirements
- R1: After reset `txd` is 1, `tx_rdy` is 1, `tx_emt` is 1, `tx_irq` is 0 and the channel is disabled.
- R2: On a command write, `cmd_data[7:4]` = 4'b0011 is the clear command. For any other upper nibble, `cmd_data[3:2]` = 2'b01 enables the channel, 2'b10 disables it, and 2'b00 or 2'b11 leave the enable state unchanged.
- R3: Each character is a low start bit, then data bits 0 to 7, then a high stop bit. Every bit lasts 16 `baud_tick` pulses. The line is high when idle.
- R4: A data write is stored only while the channel is enabled and the queue has room. Otherwise it is dropped.
- R5: `tx_rdy` is 1 exactly when the queue holds fewer bytes than its capacity. The capacity is 8 when `fifo_wide` is 0 and 16 when it is 1. The byte in the shifter does not count.
- R6: `tx_emt` is 1 only when the queue is empty and the shifter has finished the stop bit of its last character.
- R7: `tx_irq` is 1 only while enabled. With `irq_level` = 2'b00 it is 1 when the queue is empty. With any other value it is 1 when the queue holds at most half its capacity.
- R8: After a disable command, `tx_irq` is 0 from the next cycle on, and every byte queued or in the shifter is still sent in order.
- R9: An enable command while already enabled leaves queued and in-flight bytes untouched.
- R10: A clear command empties the queue and abandons any character in progress. From the next cycle on, `txd` is 1, `tx_emt` is 1, `tx_rdy` is 1, and the channel is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Oversampling tick, 16 per bit time |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 8 | Command code |
| data_we | input | 1 | Transmit data write strobe |
| data_in | input | 8 | Byte to queue |
| fifo_wide | input | 1 | Queue capacity: 0 = 8, 1 = 16 |
| irq_level | input | 2 | Request level: 00 = empty, other = half free |
| txd | output | 1 | Serial line |
| tx_rdy | output | 1 | Queue has room |
| tx_emt | output | 1 | Queue and shifter idle |
| tx_irq | output | 1 | Service request |

## Verification
The assertions assume that `fifo_wide` does not change while the queue holds more than eight bytes. They also assume that a command write and a data write are never issued in the same cycle. The bench changes the mode inputs only directly before a clear command, and it issues at most one strobe per cycle. Queue levels are set up with `baud_tick` held low, so the count is fixed and known when the flags are checked. Line checks sample the middle of each bit with the tick running at a fixed period.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam logic [3:0] CLR_NIBBLE = 4'b0011;
  localparam logic [1:0] EN_CODE    = 2'b01;
  localparam logic [1:0] DIS_CODE   = 2'b10;

  typedef enum logic [1:0] {
    TXC_NOP,
    TXC_ENABLE,
    TXC_DISABLE,
    TXC_CLEAR
  } tx_cmd_e;
endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int DW        = 8,
  parameter int DEPTH_MAX = 16,
  parameter int DEPTH_MIN = 8,
  localparam int PW = $clog2(DEPTH_MAX),
  localparam int CW = $clog2(DEPTH_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wide,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] cnt,
  output logic          room,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH_MAX];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] cap;
  logic          do_push, do_pop;

  assign cap     = wide ? CW'(DEPTH_MAX) : CW'(DEPTH_MIN);
  assign room    = cnt_q < cap;
  assign empty   = cnt_q == '0;
  assign do_push = push && room && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign dout    = mem[rp_q];
  assign cnt     = cnt_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH_MAX - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = bump(wp_q);
      if (do_pop)  rp_d = bump(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == cap && push && !pop && !flush) |=> (cnt_q == $past(cnt_q))); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty); // R6
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift #(
  parameter int DW  = 8,
  parameter int OVS = 16,
  localparam int FW  = DW + 2,
  localparam int TCW = $clog2(OVS),
  localparam int BCW = $clog2(FW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          tick,
  input  logic          avail,
  input  logic [DW-1:0] din,
  output logic          pop,
  output logic          busy,
  output logic          txd
);
  logic [FW-1:0]  sh_q, sh_d;
  logic [TCW-1:0] tc_q, tc_d;
  logic [BCW-1:0] bc_q, bc_d;
  logic           busy_q, busy_d;

  assign pop  = !busy_q && avail && !abort;
  assign busy = busy_q;
  assign txd  = busy_q ? sh_q[0] : 1'b1;

  always_comb begin
    sh_d   = sh_q;
    tc_d   = tc_q;
    bc_d   = bc_q;
    busy_d = busy_q;
    if (abort) begin
      busy_d = 1'b0;
    end else if (!busy_q) begin
      if (avail) begin
        busy_d = 1'b1;
        sh_d   = {1'b1, din, 1'b0};
        tc_d   = '0;
        bc_d   = '0;
      end
    end else if (tick) begin
      if (tc_q == TCW'(OVS - 1)) begin
        tc_d = '0;
        sh_d = {1'b1, sh_q[FW-1:1]};
        if (bc_q == BCW'(FW - 1)) busy_d = 1'b0;
        else                      bc_d   = bc_q + BCW'(1);
      end else begin
        tc_d = tc_q + TCW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      tc_q   <= '0;
      bc_q   <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      tc_q   <= tc_d;
      bc_q   <= bc_d;
      busy_q <= busy_d;
    end
  end

  AST_START_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !txd); // R3
  AST_STOP_BIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && bc_q == BCW'(FW - 1)) |-> txd); // R3
endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int DEPTH_MAX = 16,
  parameter int DEPTH_MIN = 8,
  localparam int CW = $clog2(DEPTH_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic [7:0]    cmd_data,
  input  logic          data_we,
  input  logic [CW-1:0] fifo_cnt,
  input  logic          wide,
  input  logic [1:0]    irq_level,
  output logic          enabled,
  output logic          flush,
  output logic          push,
  output logic          irq
);
  tx_cmd_e       cmd;
  logic          en_q, en_d;
  logic [CW-1:0] half;
  logic          unused_cmd_bits;

  assign unused_cmd_bits = ^cmd_data[1:0];

  always_comb begin
    cmd = TXC_NOP;
    if (cmd_we) begin
      if (cmd_data[7:4] == CLR_NIBBLE)       cmd = TXC_CLEAR;
      else if (cmd_data[3:2] == EN_CODE)     cmd = TXC_ENABLE;
      else if (cmd_data[3:2] == DIS_CODE)    cmd = TXC_DISABLE;
    end
  end

  always_comb begin
    case (cmd)
      TXC_ENABLE:             en_d = 1'b1;
      TXC_DISABLE, TXC_CLEAR: en_d = 1'b0;
      default:                en_d = en_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  assign half    = wide ? CW'(DEPTH_MAX / 2) : CW'(DEPTH_MIN / 2);
  assign enabled = en_q;
  assign flush   = cmd == TXC_CLEAR;
  assign push    = data_we && en_q && !flush;
  assign irq     = en_q && ((irq_level == 2'b00) ? (fifo_cnt == '0)
                                                 : (fifo_cnt <= half));

  AST_IRQ_OFF_AFTER_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_data[7:4] != CLR_NIBBLE && cmd_data[3:2] == DIS_CODE) |=> !irq); // R8
  AST_CLEAR_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_data[7:4] == CLR_NIBBLE) |=> !enabled); // R10
endmodule

// File: rtl/uart_tx_chan.sv
module uart_tx_chan #(
  parameter int DW        = 8,
  parameter int DEPTH_MAX = 16,
  parameter int DEPTH_MIN = 8,
  parameter int OVS       = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          cmd_we,
  input  logic [7:0]    cmd_data,
  input  logic          data_we,
  input  logic [DW-1:0] data_in,
  input  logic          fifo_wide,
  input  logic [1:0]    irq_level,
  output logic          txd,
  output logic          tx_rdy,
  output logic          tx_emt,
  output logic          tx_irq
);
  localparam int CW = $clog2(DEPTH_MAX + 1);

  logic [1:0]    rst_sync;
  logic          rst_i_n;
  logic          en, flush, push, pop, busy, room, empty;
  logic [CW-1:0] cnt;
  logic [DW-1:0] head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  uart_tx_ctrl #(.DEPTH_MAX(DEPTH_MAX), .DEPTH_MIN(DEPTH_MIN)) u_ctrl (
    .clk(clk), .rst_n(rst_i_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .data_we(data_we), .fifo_cnt(cnt), .wide(fifo_wide), .irq_level(irq_level),
    .enabled(en), .flush(flush), .push(push), .irq(tx_irq)
  );

  uart_tx_fifo #(.DW(DW), .DEPTH_MAX(DEPTH_MAX), .DEPTH_MIN(DEPTH_MIN)) u_fifo (
    .clk(clk), .rst_n(rst_i_n), .flush(flush), .wide(fifo_wide), .push(push),
    .din(data_in), .pop(pop), .dout(head), .cnt(cnt), .room(room), .empty(empty)
  );

  uart_tx_shift #(.DW(DW), .OVS(OVS)) u_shift (
    .clk(clk), .rst_n(rst_i_n), .abort(flush), .tick(baud_tick),
    .avail(!empty), .din(head), .pop(pop), .busy(busy), .txd(txd)
  );

  assign tx_rdy = room;
  assign tx_emt = empty && !busy;

  AST_EMT_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_i_n)
    tx_emt |-> txd); // R6
  AST_CLEAR_FLUSHES: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cmd_we && cmd_data[7:4] == 4'b0011) |=> (tx_emt && tx_rdy && txd)); // R10
  AST_DROP_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_i_n)
    (data_we && !en && empty) |=> empty); // R4
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cmd_we && cmd_data[7:4] == 4'b0011) |=> !tx_irq); // R7
endmodule

// File: tb/uart_tx_chan_tb.sv
module uart_tx_chan_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       cmd_we = 1'b0;
  logic [7:0] cmd_data = 8'h00;
  logic       data_we = 1'b0;
  logic [7:0] data_in = 8'h00;
  logic       fifo_wide = 1'b0;
  logic [1:0] irq_level = 2'b00;
  logic       txd, tx_rdy, tx_emt, tx_irq;

  int checks = 0;
  int failures = 0;
  int tick_per = 0;
  int tick_ph = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_tx_chan u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .cmd_we(cmd_we),
    .cmd_data(cmd_data), .data_we(data_we), .data_in(data_in),
    .fifo_wide(fifo_wide), .irq_level(irq_level), .txd(txd),
    .tx_rdy(tx_rdy), .tx_emt(tx_emt), .tx_irq(tx_irq)
  );

  always @(negedge clk) begin
    if (tick_per == 0) begin
      baud_tick = 1'b0;
      tick_ph = 0;
    end else begin
      baud_tick = (tick_ph == 0);
      tick_ph = (tick_ph + 1) % tick_per;
    end
  end

  // {en, wide, level[1:0], writes[4:0], exp_rdy, exp_irq, exp_emt}
  localparam logic [11:0] VEC [13] = '{
    {1'b1, 1'b0, 2'd0, 5'd0,  1'b1, 1'b1, 1'b1},
    {1'b1, 1'b0, 2'd0, 5'd1,  1'b1, 1'b1, 1'b0},
    {1'b1, 1'b0, 2'd0, 5'd2,  1'b1, 1'b0, 1'b0},
    {1'b1, 1'b0, 2'd1, 5'd5,  1'b1, 1'b1, 1'b0},
    {1'b1, 1'b0, 2'd1, 5'd6,  1'b1, 1'b0, 1'b0},
    {1'b1, 1'b0, 2'd1, 5'd9,  1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 2'd0, 5'd11, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b1, 2'd2, 5'd9,  1'b1, 1'b1, 1'b0},
    {1'b1, 1'b1, 2'd3, 5'd10, 1'b1, 1'b0, 1'b0},
    {1'b1, 1'b1, 2'd1, 5'd17, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b1, 2'd0, 5'd1,  1'b1, 1'b1, 1'b0},
    {1'b1, 1'b1, 2'd2, 5'd0,  1'b1, 1'b1, 1'b1},
    {1'b0, 1'b0, 2'd0, 5'd3,  1'b1, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [7:0] v);
    @(negedge clk);
    cmd_we = 1'b1; cmd_data = v;
    @(negedge clk);
    cmd_we = 1'b0; cmd_data = 8'h00;
  endtask

  task automatic send_byte(input logic [7:0] v);
    @(negedge clk);
    data_we = 1'b1; data_in = v;
    @(negedge clk);
    data_we = 1'b0;
  endtask

  task automatic get_frame(input int p, output logic [7:0] b, output logic ok);
    int guard = 0;
    ok = 1'b0;
    b = 8'h00;
    while (txd !== 1'b0 && guard < 4000) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 4000) return;
    repeat (8 * p) @(negedge clk);
    if (txd !== 1'b0) return;
    for (int i = 0; i < 8; i++) begin
      repeat (16 * p) @(negedge clk);
      b[i] = txd;
    end
    repeat (16 * p) @(negedge clk);
    check("R6 tx_emt low during stop bit", tx_emt, 1'b0);
    ok = txd;
  endtask

  task automatic expect_frame(input string req, input int p, input logic [7:0] exp);
    logic [7:0] b;
    logic ok;
    get_frame(p, b, ok);
    check({req, " frame start/stop"}, ok, 1'b1);
    check({req, " frame data"}, b, exp);
  endtask

  task automatic expect_quiet(input string req, input int n);
    logic seen_low = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) seen_low = 1'b1;
    end
    check({req, " line stays high"}, seen_low, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] b;
    logic ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 txd", txd, 1'b1);
    check("R1 tx_rdy", tx_rdy, 1'b1);
    check("R1 tx_emt", tx_emt, 1'b1);
    check("R1 tx_irq", tx_irq, 1'b0);
    send_byte(8'h77);
    @(negedge clk);
    check("R1 disabled after reset, write dropped", tx_emt, 1'b1);

    // table walk: R5 R7 R4 flag levels with the tick stopped
    for (int v = 0; v < 13; v++) begin
      tick_per = 0;
      fifo_wide = VEC[v][10];
      irq_level = VEC[v][9:8];
      send_cmd(8'h30);
      if (VEC[v][11]) send_cmd(8'h04);
      for (int k = 0; k < int'(VEC[v][7:3]); k++) begin
        @(negedge clk);
        data_we = 1'b1; data_in = 8'(k);
      end
      @(negedge clk);
      data_we = 1'b0;
      @(negedge clk);
      check($sformatf("R5 tx_rdy vec%0d", v), tx_rdy, VEC[v][2]);
      check($sformatf("R7 tx_irq vec%0d", v), tx_irq, VEC[v][1]);
      check($sformatf("R4 R6 tx_emt vec%0d", v), tx_emt, VEC[v][0]);
    end

    // R3 serialization, one tick per cycle, back to back
    fifo_wide = 1'b0; irq_level = 2'b00;
    send_cmd(8'h30);
    send_cmd(8'h04);
    tick_per = 1;
    send_byte(8'hA5);
    send_byte(8'h3C);
    send_byte(8'h81);
    expect_frame("R3 A5", 1, 8'hA5);
    expect_frame("R3 3C", 1, 8'h3C);
    expect_frame("R3 81", 1, 8'h81);
    repeat (40) @(negedge clk);
    check("R6 tx_emt after last stop bit", tx_emt, 1'b1);

    // R3 slower tick: one tick every third cycle
    tick_per = 3;
    send_byte(8'h5E);
    expect_frame("R3 tick period 3", 3, 8'h5E);
    repeat (60) @(negedge clk);

    // R8 disable drains queue, R4 write while disabled dropped
    tick_per = 0;
    irq_level = 2'b01;
    send_cmd(8'h30);
    send_cmd(8'h04);
    send_byte(8'h11);
    send_byte(8'h22);
    send_byte(8'h33);
    @(negedge clk);
    check("R7 irq at half-free level before disable", tx_irq, 1'b1);
    send_cmd(8'h08);
    check("R8 irq off after disable", tx_irq, 1'b0);
    send_byte(8'h44);
    tick_per = 1;
    expect_frame("R8 drain 11", 1, 8'h11);
    expect_frame("R8 drain 22", 1, 8'h22);
    expect_frame("R8 drain 33", 1, 8'h33);
    expect_quiet("R4 dropped write", 250);
    check("R8 idle after drain", tx_emt, 1'b1);

    // R9 re-enable while enabled, R2 no-op codes
    tick_per = 0;
    irq_level = 2'b00;
    send_cmd(8'h30);
    send_cmd(8'h04);
    send_cmd(8'h0C);
    send_cmd(8'h00);
    send_byte(8'h5A);
    send_byte(8'h6B);
    send_cmd(8'h04);
    send_cmd(8'h05);
    tick_per = 1;
    expect_frame("R9 first byte", 1, 8'h5A);
    expect_frame("R9 second byte", 1, 8'h6B);
    repeat (20) @(negedge clk);
    send_byte(8'hC3);
    expect_frame("R2 still enabled after no-op codes", 1, 8'hC3);
    repeat (20) @(negedge clk);

    // R10 clear mid character
    send_byte(8'h00);
    send_byte(8'h0F);
    repeat (40) @(negedge clk);
    check("R10 line low mid character", txd, 1'b0);
    send_cmd(8'h30);
    check("R10 txd", txd, 1'b1);
    check("R10 tx_emt", tx_emt, 1'b1);
    check("R10 tx_rdy", tx_rdy, 1'b1);
    check("R10 tx_irq", tx_irq, 1'b0);
    expect_quiet("R10 flushed", 250);
    send_byte(8'h99);
    @(negedge clk);
    check("R10 disabled after clear", tx_emt, 1'b1);

    get_frame(1, b, ok);
    check("R10 no frame after clear", ok, 1'b0);
    finish_run();
  end
endmodule